// File: doc/BRIEF.md
# Bidirectional PWM Channel Bank

This block holds a row of identical pin channels that all run at once and never share state. A per-channel direction bit picks the job for each pin at run time. As a generator, the channel drives its pin high for a programmed number of clock ticks, then low for a second programmed number, and repeats. As a meter, the channel samples its pin on every clock. It reports the length in ticks of the last complete high phase and of the last complete low phase.

A host writes the two tick counts and the direction bits through a flat write port, and reads settings and measurements through a read port with one cycle of latency. Every count is an unsigned integer of `CNT_W` bits, 32 by default. The nominal system clock is 40 MHz, but nothing in the logic depends on that rate.

Top module: `pwm_chan_bank`

## Requirements
- R1: After reset every direction bit is 1 (measure), `pin_oe` is all zeros, `pin_out` is all zeros, and every register reads 0 except the direction register, which reads all ones.
- R2: Register address = channel*4 + sel. sel 0 is the high-tick setting and sel 1 is the low-tick setting; both read back what was written. sel 2 is the measured high length and sel 3 is the measured low length; both are read-only, and writes to them are ignored. Address NUM_CH*4 holds the direction bits, bit i for channel i. `rd_data` shows the addressed value one clock after `rd_addr` is presented. Unmapped addresses read 0.
- R3: With direction 0, `pin_oe` for that channel is 1 and the generator drives `pin_out`. With direction 1, `pin_oe` is 0 and `pin_out` is held at 0.
- R4: In generate mode with high setting H>0 and low setting L>0, the pin is high for exactly H ticks and then low for exactly L ticks, and this repeats.
- R5: New settings are taken only at the start of a high phase, so no period mixes old and new values.
- R6: A high setting of 0 gives a constantly low pin. A low setting of 0 with a nonzero high setting gives a constantly high pin.
- R7: In measure mode the pin passes through a two-flop synchronizer. On each rising edge the measured low register takes the length of the low phase that just ended. On each falling edge the measured high register takes the length of the high phase that just ended. A level held for N ticks reads as N.
- R8: The first edge seen after a channel enters measure mode only starts timing and stores nothing.
- R9: The phase counter saturates at all ones rather than wrapping, so a phase longer than the count range reads as all ones.
- R10: Changing a channel's direction clears its counters. The measured registers read 0 after a change, and a generator restarts with a full high phase one tick after the change.
- R11: Channels are independent: activity on one pin or setting never alters another channel's output or measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (7) | Write register address |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (7) | Read register address |
| rd_data | output | DATA_W (32) | Read data, one clock after the address |
| pin_in | input | NUM_CH (16) | Pin levels seen by the meters |
| pin_out | output | NUM_CH (16) | Generator levels |
| pin_oe | output | NUM_CH (16) | Pin drive enables, 1 = drive |

## Verification
The generator is tried with random high/low pairs, with settings rewritten in the middle of a high phase, and with zero high or zero low counts. These cases separate correct phase lengths, latching at the period start, and the constant-level special cases. The meter is checked two ways: it is fed the generator's own output through a loopback, and it is fed hand-shaped pulse trains on another pin. The loopback tests measurement against a known source. The hand-shaped trains expose first-edge arming, saturation on a stuck pin, and clearing on a direction change. Checks on neighbouring channels during all of this catch any crosstalk.

// File: rtl/pwm_bank_pkg.sv
// Shared constants for the PWM channel bank.
// Assumes a four-slot register window per channel.
package pwm_bank_pkg;
    localparam int SLOT_W = 2;
    localparam logic [SLOT_W-1:0] SEL_HI_CFG  = 2'd0;
    localparam logic [SLOT_W-1:0] SEL_LO_CFG  = 2'd1;
    localparam logic [SLOT_W-1:0] SEL_HI_MEAS = 2'd2;
    localparam logic [SLOT_W-1:0] SEL_LO_MEAS = 2'd3;
    localparam logic DIR_GEN  = 1'b0;
    localparam logic DIR_MEAS = 1'b1;
endpackage

// File: rtl/pwm_gen.sv
// Pulse generator: high for hi_cfg ticks, then low for lo_cfg ticks, repeating.
// Settings are latched only at the start of each period.
// Assumes hold forces the idle state (used when the channel measures).
module pwm_gen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] lo_cfg,
    output logic             pwm_o
);
    logic [CNT_W-1:0] hi_cur;
    logic [CNT_W-1:0] lo_cur;
    logic [CNT_W-1:0] remain;
    logic             level;
    logic             first;
    logic             last_tick;
    logic             at_boundary;
    logic             to_low;

    // Decode where the current phase ends and what follows it.
    always_comb begin
        last_tick   = (remain <= CNT_W'(1));
        at_boundary = first | (last_tick & (~level | (lo_cur == '0)));
        to_low      = ~first & last_tick & level & (lo_cur != '0);
    end

    // Phase sequencer: latch settings at period start, then count each phase down.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            level  <= 1'b0;
            first  <= 1'b1;
            remain <= '0;
            hi_cur <= '0;
            lo_cur <= '0;
        end else if (at_boundary) begin
            first  <= 1'b0;
            hi_cur <= hi_cfg;
            lo_cur <= lo_cfg;
            level  <= (hi_cfg != '0);
            remain <= (hi_cfg != '0) ? hi_cfg : lo_cfg;
        end else if (to_low) begin
            level  <= 1'b0;
            remain <= lo_cur;
        end else begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign pwm_o = level;

    // R5: the latched settings move only at a period start.
    p_cfg_latch_r5: assert property (@(posedge clk) disable iff (!rst_n || hold)
        !at_boundary |=> ($stable(hi_cur) && $stable(lo_cur)));

    // R6: a zero high setting never produces a high level.
    p_zero_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cur == '0) |-> !level);
endmodule

// File: rtl/pwm_meas.sv
// Pulse meter: synchronises the pin, times each phase, and stores completed
// high and low lengths. Assumes hold clears all state (used when the channel generates).
module pwm_meas #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             pin_i,
    output logic [CNT_W-1:0] meas_hi,
    output logic [CNT_W-1:0] meas_lo
);
    logic             sync_a;
    logic             sync_b;
    logic             sync_prev;
    logic             armed;
    logic [CNT_W-1:0] run;
    logic             rise;
    logic             fall;

    // Two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_a    <= pin_i;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    // Edge decode on the synchronised level.
    always_comb begin
        rise = sync_b & ~sync_prev;
        fall = ~sync_b & sync_prev;
    end

    // Phase timer with saturation; stores a completed phase on each edge once armed.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            run     <= '0;
            armed   <= 1'b0;
            meas_hi <= '0;
            meas_lo <= '0;
        end else if (rise || fall) begin
            run   <= CNT_W'(1);
            armed <= 1'b1;
            if (armed && rise) meas_lo <= run;
            if (armed && fall) meas_hi <= run;
        end else if (run != '1) begin
            run <= run + CNT_W'(1);
        end
    end

    // R9: a saturated timer stays saturated while the level is unchanged.
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (run == '1 && !rise && !fall) |=> (run == '1));

    // R7: the measured high changes only after a falling edge.
    p_hi_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n || hold)
        !fall |=> $stable(meas_hi));

    // R7: the measured low changes only after a rising edge.
    p_lo_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n || hold)
        !rise |=> $stable(meas_lo));
endmodule

// File: rtl/pwm_channel.sv
// One pin channel: a generator and a meter, one active at a time per direction bit.
// The idle unit is held cleared, so any direction change restarts its counters.
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] lo_cfg,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output logic [CNT_W-1:0] meas_hi,
    output logic [CNT_W-1:0] meas_lo
);
    logic gen_hold;
    logic meas_hold;

    // Only the unit chosen by the direction bit runs.
    always_comb begin
        gen_hold  = (dir == DIR_MEAS);
        meas_hold = (dir == DIR_GEN);
        pin_oe    = (dir == DIR_GEN);
    end

    pwm_gen #(.CNT_W(CNT_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (gen_hold),
        .hi_cfg (hi_cfg),
        .lo_cfg (lo_cfg),
        .pwm_o  (pin_o)
    );

    pwm_meas #(.CNT_W(CNT_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (meas_hold),
        .pin_i   (pin_i),
        .meas_hi (meas_hi),
        .meas_lo (meas_lo)
    );

    // R3: after one full tick in measure mode the pin level is low.
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && $past(dir)) |-> !pin_o);
endmodule

// File: rtl/pwm_chan_bank.sv
// Bank of NUM_CH independent PWM channels with a flat register port.
// Address = channel*4 + slot; the direction word sits at NUM_CH*4.
// Reads are registered (one clock latency). Assumes NUM_CH <= DATA_W and CNT_W <= DATA_W.
module pwm_chan_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    localparam int DIR_ADDR = NUM_CH * 4,
    localparam int ADDR_W   = $clog2(DIR_ADDR + 1),
    localparam int CHF_W    = ADDR_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] pin_in,
    output logic [NUM_CH-1:0] pin_out,
    output logic [NUM_CH-1:0] pin_oe
);
    logic [NUM_CH-1:0]            dir_q;
    logic [NUM_CH-1:0][CNT_W-1:0] hi_cfg;
    logic [NUM_CH-1:0][CNT_W-1:0] lo_cfg;
    logic [NUM_CH-1:0][CNT_W-1:0] meas_hi;
    logic [NUM_CH-1:0][CNT_W-1:0] meas_lo;
    logic [DATA_W-1:0]            rd_next;

    // Direction word: all channels start in measure mode (pins released).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_en && wr_addr == ADDR_W'(DIR_ADDR)) begin
            dir_q <= wr_data[NUM_CH-1:0];
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Per-channel high/low settings; the measured slots are not writable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_cfg[ch] <= '0;
                lo_cfg[ch] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(ch * 4 + int'(SEL_HI_CFG))) hi_cfg[ch] <= wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(ch * 4 + int'(SEL_LO_CFG))) lo_cfg[ch] <= wr_data[CNT_W-1:0];
            end
        end

        pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (dir_q[ch]),
            .hi_cfg  (hi_cfg[ch]),
            .lo_cfg  (lo_cfg[ch]),
            .pin_i   (pin_in[ch]),
            .pin_o   (pin_out[ch]),
            .pin_oe  (pin_oe[ch]),
            .meas_hi (meas_hi[ch]),
            .meas_lo (meas_lo[ch])
        );
    end

    // Read decode: direction word, or one of the four slots of a channel, else zero.
    always_comb begin
        rd_next = '0;
        if (rd_addr == ADDR_W'(DIR_ADDR)) rd_next = DATA_W'(dir_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr[ADDR_W-1:SLOT_W] == CHF_W'(i)) begin
                case (rd_addr[SLOT_W-1:0])
                    SEL_HI_CFG:  rd_next = DATA_W'(hi_cfg[i]);
                    SEL_LO_CFG:  rd_next = DATA_W'(lo_cfg[i]);
                    SEL_HI_MEAS: rd_next = DATA_W'(meas_hi[i]);
                    default:     rd_next = DATA_W'(meas_lo[i]);
                endcase
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    // R2: a write to the direction address lands in the direction word.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(DIR_ADDR)) |=> (dir_q == $past(wr_data[NUM_CH-1:0])));

    // R3: a pin is driven only by a channel in generate mode.
    p_oe_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & dir_q) == '0));
endmodule

// File: tb/test_pwm_chan_bank.sv
module test_pwm_chan_bank;
    localparam int NCH = 16;
    localparam int CW  = 8;
    localparam int AW  = 7;
    localparam int DIRA = NCH * 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pin_in;
    logic [NCH-1:0] pin_out;
    logic [NCH-1:0] pin_oe;
    logic [NCH-1:0] drv = '0;
    logic           loop_en = 1'b0;
    int             n_chk = 0;
    int             n_fail = 0;
    int unsigned    seed_v;

    always #2 clk = ~clk;

    // Channel 1 can listen to channel 0's output.
    assign pin_in = loop_en ? {drv[NCH-1:2], pin_out[0], drv[0]} : drv;

    pwm_chan_bank #(.NUM_CH(NCH), .CNT_W(CW), .DATA_W(32)) i_pwm_chan_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int addr_of(input int ch, input int slot);
        return ch * 4 + slot;
    endfunction

    // Expected constant level for the zero-count modes (R6).
    function automatic logic const_level(input int h, input int l);
        if (h == 0) return 1'b0;
        if (l == 0) return 1'b1;
        return 1'bx;
    endfunction

    // Expected reading after saturation (R9).
    function automatic int sat_len(input int n);
        return (n > (1 << CW) - 1) ? (1 << CW) - 1 : n;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = AW'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic meas_gen(input int ch, output int h, output int l);
        int guard = 0;
        h = 0; l = 0;
        while (pin_out[ch] !== 1'b0 && guard < 3000) begin @(negedge clk); guard++; end
        while (pin_out[ch] !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
        while (pin_out[ch] === 1'b1 && guard < 3000) begin h++; @(negedge clk); guard++; end
        while (pin_out[ch] === 1'b0 && guard < 3000) begin l++; @(negedge clk); guard++; end
    endtask

    task automatic hold_pin(input int ch, input logic v, input int n);
        drv[ch] = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int h, l, hc, lc, cnt;
        seed_v = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 out", 32'(pin_out), 0);
        rd(DIRA, v); chk("R1 dir", v, 32'h0000_FFFF);
        rd(addr_of(0, 0), v); chk("R1 hi cfg", v, 0);
        rd(addr_of(5, 3), v); chk("R1 lo meas", v, 0);

        // R2 map, readback, ignored writes, unmapped
        wr(addr_of(3, 0), 8'h5A); rd(addr_of(3, 0), v); chk("R2 hi readback", v, 8'h5A);
        wr(addr_of(3, 1), 8'h21); rd(addr_of(3, 1), v); chk("R2 lo readback", v, 8'h21);
        wr(addr_of(3, 2), 8'h77); rd(addr_of(3, 2), v); chk("R2 meas write ignored", v, 0);
        rd(DIRA + 1, v); chk("R2 unmapped", v, 0);

        // R3/R4 channel 0 generates, the rest measure
        wr(addr_of(0, 0), 5); wr(addr_of(0, 1), 3); wr(DIRA, 16'hFFFE);
        chk("R3 oe", 32'(pin_oe), 1);
        meas_gen(0, h, l); meas_gen(0, h, l);
        chk("R4 high len", h, 5); chk("R4 low len", l, 3);
        chk("R3 idle outs", 32'(pin_out[NCH-1:1]), 0);

        // R4/R7 random settings with loopback into channel 1
        loop_en = 1'b1;
        for (int it = 0; it < 6; it++) begin
            int rh, rl;
            rh = 1 + int'($urandom % 40); rl = 1 + int'($urandom % 40);
            wr(addr_of(0, 0), rh); wr(addr_of(0, 1), rl);
            meas_gen(0, h, l); meas_gen(0, h, l);
            chk("R4 random high", h, rh); chk("R4 random low", l, rl);
            repeat (4) @(negedge clk);
            rd(addr_of(1, 2), v); chk("R7 loop high", v, rh);
            rd(addr_of(1, 3), v); chk("R7 loop low", v, rl);
        end

        // R5 rewrite in the middle of a high phase
        wr(addr_of(0, 0), 10); wr(addr_of(0, 1), 10);
        meas_gen(0, h, l); meas_gen(0, h, l);
        hc = 1;
        wr_en = 1'b1; wr_addr = AW'(addr_of(0, 0)); wr_data = 4;
        @(negedge clk); if (pin_out[0]) hc++;
        wr_addr = AW'(addr_of(0, 1)); wr_data = 6;
        @(negedge clk); if (pin_out[0]) hc++;
        wr_en = 1'b0;
        while (pin_out[0] === 1'b1 && hc < 50) begin @(negedge clk); if (pin_out[0]) hc++; end
        lc = 0;
        while (pin_out[0] === 1'b0 && lc < 50) begin lc++; @(negedge clk); end
        chk("R5 current high kept", hc, 10); chk("R5 current low kept", lc, 10);
        meas_gen(0, h, l);
        chk("R5 next high new", h, 4); chk("R5 next low new", l, 6);

        // R6 zero counts
        wr(addr_of(0, 0), 0); wr(addr_of(0, 1), 5);
        repeat (30) @(negedge clk);
        cnt = 0; for (int k = 0; k < 20; k++) begin if (pin_out[0] === const_level(0, 5)) cnt++; @(negedge clk); end
        chk("R6 zero high constant low", cnt, 20);
        wr(addr_of(0, 0), 7); wr(addr_of(0, 1), 0);
        repeat (30) @(negedge clk);
        cnt = 0; for (int k = 0; k < 20; k++) begin if (pin_out[0] === const_level(7, 0)) cnt++; @(negedge clk); end
        chk("R6 zero low constant high", cnt, 20);

        // R10 generator restart after a direction change
        wr(addr_of(0, 0), 6); wr(addr_of(0, 1), 4);
        wr(DIRA, 16'hFFFF);
        @(negedge clk);
        chk("R3 measure mode low", 32'(pin_out[0]), 0);
        chk("R3 measure mode oe", 32'(pin_oe[0]), 0);
        wr(DIRA, 16'hFFFE);
        chk("R10 idle before start", 32'(pin_out[0]), 0);
        cnt = 0; for (int k = 0; k < 6; k++) begin @(negedge clk); if (pin_out[0]) cnt++; end
        chk("R10 full first high", cnt, 6);
        @(negedge clk); chk("R10 low after first high", 32'(pin_out[0]), 0);

        // R10 meter clear on direction change (loopback off)
        loop_en = 1'b0; drv = '0;
        repeat (4) @(negedge clk);
        wr(DIRA, 16'hFFFC); wr(DIRA, 16'hFFFE);
        rd(addr_of(1, 2), v); chk("R10 meas high cleared", v, 0);
        rd(addr_of(1, 3), v); chk("R10 meas low cleared", v, 0);

        // R8 first edge only arms (channel 2 entered measure mode at the write above)
        wr(DIRA, 16'hFFFA); wr(DIRA, 16'hFFFE);
        hold_pin(2, 1'b0, 8);
        hold_pin(2, 1'b1, 5);
        drv[2] = 1'b0; repeat (10) @(negedge clk);
        rd(addr_of(2, 2), v); chk("R7 high after fall", v, 5);
        rd(addr_of(2, 3), v); chk("R8 first rise not stored", v, 0);
        repeat (8) @(negedge clk);
        hold_pin(2, 1'b1, 9);
        drv[2] = 1'b0; repeat (10) @(negedge clk);
        rd(addr_of(2, 3), v); chk("R7 low length", v, 20);
        rd(addr_of(2, 2), v); chk("R7 high length", v, 9);

        // R7/R11 random pulses on channel 2 while channel 0 runs
        for (int it = 0; it < 4; it++) begin
            int ph, pl;
            ph = 1 + int'($urandom % 60); pl = 1 + int'($urandom % 60);
            hold_pin(2, 1'b0, 4); hold_pin(2, 1'b1, ph); hold_pin(2, 1'b0, pl); hold_pin(2, 1'b1, 6);
            rd(addr_of(2, 2), v); chk("R7 random high", v, ph);
            rd(addr_of(2, 3), v); chk("R7 random low", v, pl);
            rd(addr_of(4, 2), v); chk("R11 quiet neighbour", v, 0);
        end
        meas_gen(0, h, l);
        chk("R11 ch0 high unaffected", h, 6); chk("R11 ch0 low unaffected", l, 4);

        // R9 saturation on a stuck pin
        hold_pin(2, 1'b0, 5); hold_pin(2, 1'b1, 300); hold_pin(2, 1'b0, 10);
        rd(addr_of(2, 2), v); chk("R9 saturated high", v, sat_len(300));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule